// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block decides when a shadow SRAM is copied into its nonvolatile backing array and when the backing array is copied back. It watches a digital supply-good flag from a trip comparator, a hardware store pin, software store and recall requests, and status-register write notifications from the serial front end. It keeps the array-modified flag, drives level strobes toward the backing-store model for a parameterised number of clock cycles, and raises a busy flag that tells the serial front end to refuse all traffic.

The first time the supply comes good after reset, the block runs one recall. When the supply falls, it stores only if auto-store is enabled and the array holds unsaved writes. A rising edge on the hardware pin stores (if needed) and then always runs a status write cycle that sets the event bit. A store requested while a status write cycle is running is held until that cycle ends.

Top module: `nvb_seq_top`

## Requirements
- R1: While reset is asserted and after it, until the supply first comes good, busy_o is 1, am_o is 0 and all strobes are 0. On the first rise of supply_ok_i after reset, recall_o is 1 for exactly T_RECALL cycles, and busy_o then falls.
- R2: A sram_wr_i pulse while busy_o is 0 sets am_o on the next cycle. am_o is cleared in the cycle where a completed store or recall drops its strobe.
- R3: When supply_ok_i falls while idle, with ase_i=1 and am_o=1, store_o is 1 for exactly T_STORE cycles, and abort_o pulses for its first cycle. If ase_i=0 or am_o=0, no store runs.
- R4: sw_store_i starts a T_STORE store whatever am_o and ase_i are. sw_recall_i starts a T_RECALL recall that clears am_o. Neither pulses abort_o.
- R5: hs_pin_i passes a two-flop synchroniser, and the store logic acts on its rising edge. With am_o=1 the edge gives an abort_o pulse, a T_STORE store, then a T_WC write cycle (wcyc_o). With am_o=0 it gives only the write cycle. In both cases event_set_o pulses for one cycle in the cycle after wcyc_o falls.
- R6: hs_pin_i edges during a store, during a recall or while the supply is low have no effect. A pin held high triggers only once.
- R7: A supply rise after the first one since reset brings no recall.
- R8: If supply_ok_i falls during a recall, recall_o drops on the next cycle, am_o is unchanged and no store runs.
- R9: stat_wr_i while idle gives a T_WC write cycle with no event_set_o pulse.
- R10: A supply fall during a write cycle defers the decision to the end of that cycle. The store then runs only if ase_i=1 and am_o=1 at that point. A hardware pin edge during a write cycle is served after the cycle ends.
- R11: While busy_o is 1, sw_store_i, sw_recall_i, stat_wr_i and sram_wr_i have no effect. busy_o is 1 whenever a strobe or wcyc_o is 1.
- R12: A started store runs its full T_STORE cycles even if the supply changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| supply_ok_i | input | 1 | 1 while the storage capacitor is above the trip point |
| hs_pin_i | input | 1 | Asynchronous hardware store pin |
| sram_wr_i | input | 1 | One pulse per data byte written into the SRAM |
| sw_store_i | input | 1 | Software store request pulse |
| sw_recall_i | input | 1 | Software recall request pulse |
| stat_wr_i | input | 1 | Status register write completed, start write cycle |
| ase_i | input | 1 | Current auto-store enable bit |
| busy_o | output | 1 | Serial front end must refuse traffic |
| am_o | output | 1 | Array modified since last store or recall |
| store_o | output | 1 | Store strobe, high for the store duration |
| recall_o | output | 1 | Recall strobe, high for the recall duration |
| wcyc_o | output | 1 | Status write cycle in progress |
| abort_o | output | 1 | One-cycle pulse: abort the transaction in progress |
| event_set_o | output | 1 | One-cycle pulse: set the event bit |

## Verification
The bench aims at the ordering corners. One is a supply fall during a write cycle with the enable bit cleared and then set: a design that decides at the fall instead of at the end of the cycle stores when it must not, or starts the store early. Another is a supply drop during the power-up recall: a design that does not abort keeps recall_o high and later clears am_o, and one that treats the drop as a store trigger emits a store. A pin held high, pin edges during a store or while the supply is low, and requests while busy are all exercised. A design that retriggers or latches these produces extra scoreboard items. Every strobe's length is measured, so an off-by-one in the timer shows up as a wrong duration.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

  typedef enum logic [2:0] {
    ST_DOWN   = 3'd0,
    ST_IDLE   = 3'd1,
    ST_RECALL = 3'd2,
    ST_STORE  = 3'd3,
    ST_WCYC   = 3'd4
  } nvb_state_e;

  typedef enum logic [1:0] {
    TRG_SW   = 2'd0,
    TRG_AUTO = 2'd1,
    TRG_HW   = 2'd2
  } nvb_trig_e;

  function automatic int unsigned nvb_max3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nvb_hs_sync.sv
module nvb_hs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/nvb_op_timer.sv
module nvb_op_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvb_am_flag.sv
module nvb_am_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic busy_i,
  input  logic clr_i,
  output logic am_o
);
  logic am_q, am_d, am_en;

  always_comb begin
    am_en = clr_i | (wr_i & ~busy_i);
    am_d  = ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      am_q <= 1'b0;
    end else if (am_en) begin
      am_q <= am_d;
    end
  end

  assign am_o = am_q;

  // R11
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clr_i && !am_q) |=> !am_q);
endmodule

// File: rtl/nvb_seq_fsm.sv
module nvb_seq_fsm
  import nvb_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned T_STORE  = 12,
  parameter int unsigned T_RECALL = 8,
  parameter int unsigned T_WC     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic             hs_rise_i,
  input  logic             sw_store_i,
  input  logic             sw_recall_i,
  input  logic             stat_wr_i,
  input  logic             ase_i,
  input  logic             am_i,
  input  logic             tmr_zero_i,
  output nvb_state_e       st_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             am_clr_o,
  output logic             abort_o,
  output logic             evset_o
);
  localparam logic [CNT_W-1:0] LD_STORE  = CNT_W'(T_STORE - 1);
  localparam logic [CNT_W-1:0] LD_RECALL = CNT_W'(T_RECALL - 1);
  localparam logic [CNT_W-1:0] LD_WC     = CNT_W'(T_WC - 1);

  nvb_state_e st_q, st_d;
  nvb_trig_e  kind_q, kind_d;
  logic       evt_q, evt_d;
  logic       pend_auto_q, pend_auto_d;
  logic       pend_hw_q, pend_hw_d;
  logic       seen_q, seen_d;
  logic       abort_q, abort_d;
  logic       evset_q, evset_d;
  logic       auto_now, hw_now;

  always_comb begin
    st_d        = st_q;
    kind_d      = kind_q;
    evt_d       = evt_q;
    pend_auto_d = pend_auto_q;
    pend_hw_d   = pend_hw_q;
    seen_d      = seen_q;
    abort_d     = 1'b0;
    evset_d     = 1'b0;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    am_clr_o    = 1'b0;
    auto_now    = pend_auto_q | ~supply_ok_i;
    hw_now      = pend_hw_q | (hs_rise_i & supply_ok_i);

    case (st_q)
      ST_DOWN: begin
        if (supply_ok_i) begin
          if (!seen_q) begin
            st_d       = ST_RECALL;
            seen_d     = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = LD_RECALL;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end

      ST_IDLE: begin
        if (!supply_ok_i) begin
          if (ase_i && am_i) begin
            st_d       = ST_STORE;
            kind_d     = TRG_AUTO;
            abort_d    = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = LD_STORE;
          end else begin
            st_d = ST_DOWN;
          end
        end else if (hs_rise_i) begin
          tmr_load_o = 1'b1;
          if (am_i) begin
            st_d      = ST_STORE;
            kind_d    = TRG_HW;
            abort_d   = 1'b1;
            tmr_val_o = LD_STORE;
          end else begin
            st_d        = ST_WCYC;
            evt_d       = 1'b1;
            pend_auto_d = 1'b0;
            pend_hw_d   = 1'b0;
            tmr_val_o   = LD_WC;
          end
        end else if (sw_store_i) begin
          st_d       = ST_STORE;
          kind_d     = TRG_SW;
          tmr_load_o = 1'b1;
          tmr_val_o  = LD_STORE;
        end else if (sw_recall_i) begin
          st_d       = ST_RECALL;
          tmr_load_o = 1'b1;
          tmr_val_o  = LD_RECALL;
        end else if (stat_wr_i) begin
          st_d        = ST_WCYC;
          evt_d       = 1'b0;
          pend_auto_d = 1'b0;
          pend_hw_d   = 1'b0;
          tmr_load_o  = 1'b1;
          tmr_val_o   = LD_WC;
        end
      end

      ST_RECALL: begin
        if (!supply_ok_i) begin
          st_d = ST_DOWN;
        end else if (tmr_zero_i) begin
          st_d     = ST_IDLE;
          am_clr_o = 1'b1;
        end
      end

      ST_STORE: begin
        if (tmr_zero_i) begin
          am_clr_o = 1'b1;
          if (kind_q == TRG_HW) begin
            st_d        = ST_WCYC;
            evt_d       = 1'b1;
            pend_auto_d = 1'b0;
            pend_hw_d   = 1'b0;
            tmr_load_o  = 1'b1;
            tmr_val_o   = LD_WC;
          end else if (kind_q == TRG_AUTO) begin
            st_d = ST_DOWN;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end

      ST_WCYC: begin
        pend_auto_d = auto_now;
        pend_hw_d   = hw_now;
        if (tmr_zero_i) begin
          evset_d     = evt_q;
          pend_auto_d = 1'b0;
          pend_hw_d   = 1'b0;
          if (auto_now) begin
            if (ase_i && am_i) begin
              st_d       = ST_STORE;
              kind_d     = TRG_AUTO;
              tmr_load_o = 1'b1;
              tmr_val_o  = LD_STORE;
            end else begin
              st_d = ST_DOWN;
            end
          end else if (hw_now) begin
            tmr_load_o = 1'b1;
            if (am_i) begin
              st_d      = ST_STORE;
              kind_d    = TRG_HW;
              tmr_val_o = LD_STORE;
            end else begin
              st_d      = ST_WCYC;
              evt_d     = 1'b1;
              tmr_val_o = LD_WC;
            end
          end else begin
            st_d = ST_IDLE;
          end
        end
      end

      default: st_d = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_DOWN;
      kind_q      <= TRG_SW;
      evt_q       <= 1'b0;
      pend_auto_q <= 1'b0;
      pend_hw_q   <= 1'b0;
      seen_q      <= 1'b0;
      abort_q     <= 1'b0;
      evset_q     <= 1'b0;
    end else begin
      st_q        <= st_d;
      kind_q      <= kind_d;
      evt_q       <= evt_d;
      pend_auto_q <= pend_auto_d;
      pend_hw_q   <= pend_hw_d;
      seen_q      <= seen_d;
      abort_q     <= abort_d;
      evset_q     <= evset_d;
    end
  end

  assign st_o    = st_q;
  assign abort_o = abort_q;
  assign evset_o = evset_q;

  // R12
  store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STORE && !tmr_zero_i) |=> (st_q == ST_STORE));

  // R8
  recall_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RECALL && !supply_ok_i) |=> (st_q == ST_DOWN));
endmodule

// File: rtl/nvb_seq_top.sv
module nvb_seq_top
  import nvb_pkg::*;
#(
  parameter int unsigned T_STORE  = 12,
  parameter int unsigned T_RECALL = 8,
  parameter int unsigned T_WC     = 6,
  parameter int unsigned HS_SYNC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic hs_pin_i,
  input  logic sram_wr_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic stat_wr_i,
  input  logic ase_i,
  output logic busy_o,
  output logic am_o,
  output logic store_o,
  output logic recall_o,
  output logic wcyc_o,
  output logic abort_o,
  output logic event_set_o
);
  localparam int unsigned T_MAX = nvb_max3(T_STORE, T_RECALL, T_WC);
  localparam int unsigned CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             hs_rise;
  logic             tmr_load, tmr_zero, am_clr, am;
  logic [CNT_W-1:0] tmr_val;
  nvb_state_e       st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  nvb_hs_sync #(.STAGES(HS_SYNC)) hs_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .pin_i  (hs_pin_i),
    .rise_o (hs_rise)
  );

  nvb_op_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  nvb_seq_fsm #(
    .CNT_W   (CNT_W),
    .T_STORE (T_STORE),
    .T_RECALL(T_RECALL),
    .T_WC    (T_WC)
  ) fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .supply_ok_i(supply_ok_i),
    .hs_rise_i  (hs_rise),
    .sw_store_i (sw_store_i),
    .sw_recall_i(sw_recall_i),
    .stat_wr_i  (stat_wr_i),
    .ase_i      (ase_i),
    .am_i       (am),
    .tmr_zero_i (tmr_zero),
    .st_o       (st),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .am_clr_o   (am_clr),
    .abort_o    (abort_o),
    .evset_o    (event_set_o)
  );

  nvb_am_flag am_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .wr_i   (sram_wr_i),
    .busy_i (busy_o),
    .clr_i  (am_clr),
    .am_o   (am)
  );

  assign am_o     = am;
  assign store_o  = (st == ST_STORE);
  assign recall_o = (st == ST_RECALL);
  assign wcyc_o   = (st == ST_WCYC);
  assign busy_o   = (st != ST_IDLE) | ~supply_ok_i;

  // R2
  am_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $fell(store_o) |-> !am_o);

  // R3
  abort_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    abort_o |-> store_o);

  // R11
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (store_o || recall_o || wcyc_o) |-> busy_o);
endmodule

// File: tb/nvb_seq_top_tb_top.sv
module nvb_seq_top_tb_top;
  localparam int TS = 12;
  localparam int TR = 8;
  localparam int TW = 6;
  localparam int K_ABORT = 0, K_STORE = 1, K_RECALL = 2, K_WCYC = 3, K_EVSET = 4;

  logic clk = 1'b0;
  logic rst_n, supply_ok, hs_pin, sram_wr, sw_store, sw_recall, stat_wr, ase;
  logic busy, am, store, recall, wcyc, abort_p, evset;

  typedef struct {
    int    kind;
    int    len;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  int    run_len [5];
  string kname [5] = '{"abort", "store", "recall", "wcyc", "event_set"};
  bit    done = 1'b0;

  always #4 clk = ~clk;

  nvb_seq_top #(.T_STORE(TS), .T_RECALL(TR), .T_WC(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .hs_pin_i(hs_pin),
    .sram_wr_i(sram_wr), .sw_store_i(sw_store), .sw_recall_i(sw_recall),
    .stat_wr_i(stat_wr), .ase_i(ase), .busy_o(busy), .am_o(am),
    .store_o(store), .recall_o(recall), .wcyc_o(wcyc), .abort_o(abort_p),
    .event_set_o(evset)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp_v);
    end
  endtask

  task automatic expect_op(input int kind, input int len, input string tag);
    exp_t e;
    e.kind = kind; e.len = len; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    step(1);
    s = 1'b0;
  endtask

  // Monitor: measures every strobe run and compares it against the queue head.
  always @(negedge clk) begin
    logic [4:0] v;
    v = {evset, wcyc, recall, store, abort_p};
    for (int k = 0; k < 5; k++) begin
      if (v[k] === 1'b1) begin
        run_len[k]++;
      end else if (run_len[k] != 0) begin
        checks++;
        if (sb_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected %s actual_len=%0d expected=none", kname[k], run_len[k]);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (e.kind != k || e.len != run_len[k]) begin
            errors++;
            $display("FAIL %s actual=%s/%0d expected=%s/%0d", e.tag, kname[k], run_len[k],
                     kname[e.kind], e.len);
          end
        end
        run_len[k] = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 5; k++) run_len[k] = 0;
    rst_n = 0; supply_ok = 0; hs_pin = 0; sram_wr = 0; sw_store = 0;
    sw_recall = 0; stat_wr = 0; ase = 0;
    step(3);
    check("R1", busy, 1'b1, "busy in reset");
    check("R1", am, 1'b0, "am in reset");
    check("R1", store | recall | wcyc, 1'b0, "strobes in reset");
    rst_n = 1;
    step(4);
    check("R1", busy, 1'b1, "busy before supply good");

    // R1 power-up recall
    expect_op(K_RECALL, TR, "R1");
    supply_ok = 1;
    step(TR + 3);
    check("R1", busy, 1'b0, "idle after recall");

    // R2 set by write
    pulse(sram_wr);
    check("R2", am, 1'b1, "am after write");

    // R4 software recall clears am
    expect_op(K_RECALL, TR, "R4");
    pulse(sw_recall);
    step(TR + 2);
    check("R4", am, 1'b0, "am after sw recall");

    // R3 supply fall, ase=0 -> no store; R7 no second recall
    pulse(sram_wr);
    supply_ok = 0;
    step(4);
    check("R3", store, 1'b0, "no store with ase=0");
    check("R3", busy, 1'b1, "busy while supply low");
    supply_ok = 1;
    step(3);
    check("R7", busy, 1'b0, "idle without recall");
    check("R3", am, 1'b1, "am kept with ase=0");

    // R3 auto store with ase=1, am=1; R12 supply returns mid-store
    ase = 1;
    expect_op(K_ABORT, 1, "R3");
    expect_op(K_STORE, TS, "R12");
    supply_ok = 0;
    step(3);
    supply_ok = 1;
    step(TS + 3);
    check("R2", am, 1'b0, "am after auto store");
    check("R3", busy, 1'b0, "idle after auto store");

    // R3 supply fall with am=0 -> no store
    supply_ok = 0;
    step(4);
    supply_ok = 1;
    step(3);
    check("R3", busy, 1'b0, "idle after fall with am=0");

    // R4 software store regardless of am/ase; R11 requests during busy
    ase = 0;
    expect_op(K_STORE, TS, "R4");
    pulse(sw_store);
    check("R4", busy, 1'b1, "busy during sw store");
    step(2);
    sram_wr = 1; sw_recall = 1; stat_wr = 1;
    step(1);
    sram_wr = 0; sw_recall = 0; stat_wr = 0;
    step(TS + 2);
    check("R11", am, 1'b0, "write during busy ignored");
    check("R11", busy, 1'b0, "idle after sw store");

    // R5 hardware store with am=1; R6 held pin does not retrigger
    pulse(sram_wr);
    expect_op(K_ABORT, 1, "R5");
    expect_op(K_STORE, TS, "R5");
    expect_op(K_WCYC, TW, "R5");
    expect_op(K_EVSET, 1, "R5");
    hs_pin = 1;
    step(3 + TS + TW + 4);
    check("R5", am, 1'b0, "am after hw store");
    step(6);
    check("R6", busy, 1'b0, "held pin no retrigger");
    hs_pin = 0;
    step(3);

    // R5 hardware edge with am=0 -> write cycle only
    expect_op(K_WCYC, TW, "R5");
    expect_op(K_EVSET, 1, "R5");
    hs_pin = 1;
    step(2);
    hs_pin = 0;
    step(TW + 6);

    // R6 pin edge during store and while supply low is ignored
    expect_op(K_STORE, TS, "R6");
    pulse(sw_store);
    step(1);
    hs_pin = 1;
    step(2);
    hs_pin = 0;
    step(TS + 2);
    supply_ok = 0;
    step(2);
    hs_pin = 1;
    step(3);
    hs_pin = 0;
    step(3);
    supply_ok = 1;
    step(4);
    check("R6", busy, 1'b0, "idle after ignored pin");

    // R9 status write cycle, no event
    expect_op(K_WCYC, TW, "R9");
    pulse(stat_wr);
    step(TW + 3);
    check("R9", evset, 1'b0, "no event after status write");

    // R10 supply fall during write cycle, ase=0 at its end -> no store
    pulse(sram_wr);
    expect_op(K_WCYC, TW, "R10");
    pulse(stat_wr);
    step(1);
    supply_ok = 0;
    step(TW + 4);
    supply_ok = 1;
    step(3);
    check("R10", am, 1'b1, "no deferred store with ase=0");

    // R10 same with ase=1 -> store after cycle
    ase = 1;
    expect_op(K_WCYC, TW, "R10");
    expect_op(K_STORE, TS, "R10");
    pulse(stat_wr);
    step(1);
    supply_ok = 0;
    step(TW + TS + 4);
    supply_ok = 1;
    step(3);
    check("R10", am, 1'b0, "deferred store cleared am");

    // R10 pin edge during write cycle served afterwards
    pulse(sram_wr);
    expect_op(K_WCYC, TW, "R10");
    expect_op(K_STORE, TS, "R10");
    expect_op(K_WCYC, TW, "R10");
    expect_op(K_EVSET, 1, "R10");
    pulse(stat_wr);
    hs_pin = 1;
    step(2);
    hs_pin = 0;
    step(TW + TS + TW + 6);
    check("R10", busy, 1'b0, "idle after deferred hw store");

    // R8 supply drop during power-up recall
    rst_n = 0; supply_ok = 0;
    step(3);
    rst_n = 1;
    step(4);
    expect_op(K_RECALL, 3, "R8");
    supply_ok = 1;
    step(3);
    supply_ok = 0;
    step(1);
    check("R8", recall, 1'b0, "recall aborted");
    step(4);
    check("R8", store, 1'b0, "no store after aborted recall");
    supply_ok = 1;
    step(4);
    check("R7", busy, 1'b0, "no recall on later rise");
    check("R8", am, 1'b0, "am unchanged");

    step(5);
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      errors++;
      $display("FAIL %s actual=missing expected=%s/%0d", e.tag, kname[e.kind], e.len);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule